// File: doc/BRIEF.md
# Status Register Mode Stack

This block keeps the 32-bit processor status word, which holds condition codes and mode flags. It also switches between the user and kernel stack pointers. The status word works as a three-deep stack of 10-bit flag fields that sits below two fixed top bits:

- Taking an exception pushes the live field up one level.
- Returning from an exception pops it back down.
- Software can also set flags, clear flags, or overwrite the whole word.

When an operation moves the machine into user mode, the block does two things. It saves the stack pointer it is given as the kernel stack pointer, and it presents the user stack pointer as the new stack pointer.

A caller drives a 3-bit operation code, a 32-bit mask or data word, the current stack pointer and the user stack pointer, and pulses a strobe for one cycle. All state updates on that rising edge. The register value is read directly from the status output at any time.

Top module: `sr_mode_stack`

## Requirements
- R1: Reset clears the status word, the stack-pointer output and the saved kernel stack pointer to zero.
- R2: A push (code 1) keeps bits 31:30, loads bits 29:10 from the old bits 19:0, and clears bits 9:0.
- R3: A pop (code 2) keeps bits 31:30, loads bits 17:0 from the old bits 27:10, and clears bits 29:18.
- R4: When the result of a pop has the user flag set (bit USER_BIT, default 8), the kernel stack pointer takes the current stack pointer and the stack-pointer output takes the user stack pointer.
- R5: A set-flags operation (code 3) ORs the mask into the status word. It swaps stack pointers only when the user flag was clear before and the mask sets it.
- R6: A clear-flags operation (code 4) ANDs the status word with the inverted mask and never swaps stack pointers.
- R7: A direct write (code 5) loads the data word into the status word without any swap.
- R8: A recognised operation that does not swap loads the stack-pointer output from the current stack pointer and leaves the kernel stack pointer unchanged.
- R9: With the strobe low, or with codes 0, 6 or 7, the status word and both stack-pointer outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 3 | Operation: 1 push, 2 pop, 3 set, 4 clear, 5 write |
| op_data | input | 32 | Flag mask, or the word for a direct write |
| sp_in | input | 32 | Current stack pointer |
| usp_in | input | 32 | User stack pointer |
| stat_q | output | 32 | Status word |
| sp_out | output | 32 | New stack pointer |
| ksp_q | output | 32 | Saved kernel stack pointer |

## Verification
The bench builds the block with the default user-flag position, bit 8. At that position a pop of a word holding bit 18 lands exactly on the user flag, so a swap caused by a pop can be reached from a plain write. Three pushes in a row push a set bit past bit 29 and show it being dropped. A pop of an all-ones low word shows bits 29:28 being discarded along with the zero fill of bits 29:18.

// File: rtl/sr_stack_pkg.sv
package sr_stack_pkg;
  localparam int SR_W     = 32;
  localparam int SR_KEEP  = 2;
  localparam int SR_FIELD = 10;
  localparam int SR_LOW_W = SR_W - SR_KEEP;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_SETF  = 3'd3,
    OP_CLRF  = 3'd4,
    OP_WRITE = 3'd5
  } sr_op_e;

  // Shift the flag stack up by one field; the fixed top bits ride along.
  function automatic logic [SR_W-1:0] push_word(input logic [SR_W-1:0] w);
    logic [SR_LOW_W-1:0] low;
    low = w[SR_LOW_W-1:0] << SR_FIELD;
    return {w[SR_W-1:SR_LOW_W], low};
  endfunction

  // Shift the flag stack down by one field; the bits just under the fixed top are dropped.
  function automatic logic [SR_W-1:0] pop_word(input logic [SR_W-1:0] w);
    logic [SR_LOW_W-1:0] low;
    low = {{SR_KEEP{1'b0}}, w[SR_LOW_W-SR_KEEP-1:0]} >> SR_FIELD;
    return {w[SR_W-1:SR_LOW_W], low};
  endfunction

  function automatic logic op_known(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd5);
  endfunction
endpackage

// File: rtl/sr_next_state.sv
module sr_next_state
  import sr_stack_pkg::*;
#(
  parameter int USER_BIT = 8
) (
  input  logic [2:0]      op_code,
  input  logic [SR_W-1:0] op_data,
  input  logic [SR_W-1:0] cur,
  output logic [SR_W-1:0] nxt,
  output logic            swap
);
  always_comb begin
    nxt  = cur;
    swap = 1'b0;
    case (op_code)
      OP_PUSH:  nxt = push_word(cur);
      OP_POP: begin
        nxt  = pop_word(cur);
        swap = nxt[USER_BIT];
      end
      OP_SETF: begin
        nxt  = cur | op_data;
        swap = !cur[USER_BIT] && op_data[USER_BIT];
      end
      OP_CLRF:  nxt = cur & ~op_data;
      OP_WRITE: nxt = op_data;
      default:  nxt = cur;
    endcase
  end

  // R4
  always_comb begin
    if (swap) begin
      swap_user_chk: assert (nxt[USER_BIT]);
    end
  end
endmodule

// File: rtl/sr_sp_bank.sv
module sr_sp_bank
  import sr_stack_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            apply,
  input  logic            swap,
  input  logic [SR_W-1:0] sp_in,
  input  logic [SR_W-1:0] usp_in,
  output logic [SR_W-1:0] sp_out,
  output logic [SR_W-1:0] ksp_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_out <= '0;
      ksp_q  <= '0;
    end else if (apply) begin
      if (swap) begin
        ksp_q  <= sp_in;
        sp_out <= usp_in;
      end else begin
        sp_out <= sp_in;
      end
    end
  end

  // R4
  swap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && swap) |=> (sp_out == $past(usp_in)) && (ksp_q == $past(sp_in)));
  // R8
  noswap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !swap) |=> (sp_out == $past(sp_in)) && $stable(ksp_q));
endmodule

// File: rtl/sr_mode_stack.sv
module sr_mode_stack
  import sr_stack_pkg::*;
#(
  parameter int USER_BIT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [SR_W-1:0] op_data,
  input  logic [SR_W-1:0] sp_in,
  input  logic [SR_W-1:0] usp_in,
  output logic [SR_W-1:0] stat_q,
  output logic [SR_W-1:0] sp_out,
  output logic [SR_W-1:0] ksp_q
);
  logic [SR_W-1:0] stat_nxt;
  logic            swap_req;
  logic            apply;

  assign apply = op_valid && op_known(op_code);

  sr_next_state #(.USER_BIT(USER_BIT)) u_next (
    .op_code (op_code),
    .op_data (op_data),
    .cur     (stat_q),
    .nxt     (stat_nxt),
    .swap    (swap_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     stat_q <= '0;
    else if (apply) stat_q <= stat_nxt;
  end

  sr_sp_bank u_sp (
    .clk    (clk),
    .rst_n  (rst_n),
    .apply  (apply),
    .swap   (swap_req),
    .sp_in  (sp_in),
    .usp_in (usp_in),
    .sp_out (sp_out),
    .ksp_q  (ksp_q)
  );

  // R2
  keep_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_PUSH || op_code == OP_POP))
      |=> stat_q[SR_W-1:SR_LOW_W] == $past(stat_q[SR_W-1:SR_LOW_W]));
  // R5
  setf_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SETF) |=> ((stat_q & $past(op_data)) == $past(op_data)));
  // R6
  clrf_noswap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CLRF) |=> ((stat_q & $past(op_data)) == '0) && $stable(ksp_q));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(stat_q) && $stable(sp_out) && $stable(ksp_q));
endmodule

// File: tb/tb_sr_mode_stack.sv
module tb_sr_mode_stack;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [31:0] op_data = '0, sp_in = '0, usp_in = '0;
  logic [31:0] stat_q, sp_out, ksp_q;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_mode_stack dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_data(op_data), .sp_in(sp_in), .usp_in(usp_in),
    .stat_q(stat_q), .sp_out(sp_out), .ksp_q(ksp_q)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  req;
    logic [31:0] data, sp, usp, xs, xsp, xk;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd5, 8'd7, 32'hC000_0003, 32'h100, 32'h200, 32'hC000_0003, 32'h100, 32'h0},   // R7
    '{3'd1, 8'd2, 32'h0,         32'h100, 32'h200, 32'hC000_0C00, 32'h100, 32'h0},   // R2
    '{3'd1, 8'd2, 32'h0,         32'h100, 32'h200, 32'hC030_0000, 32'h100, 32'h0},   // R2
    '{3'd2, 8'd3, 32'h0,         32'h110, 32'h200, 32'hC000_0C00, 32'h110, 32'h0},   // R3 R8
    '{3'd5, 8'd7, 32'h0004_0000, 32'h110, 32'h200, 32'h0004_0000, 32'h110, 32'h0},   // R7
    '{3'd2, 8'd4, 32'h0,         32'h120, 32'h800, 32'h0000_0100, 32'h800, 32'h120}, // R4
    '{3'd4, 8'd6, 32'h100,       32'h800, 32'h900, 32'h0,         32'h800, 32'h120}, // R6
    '{3'd3, 8'd5, 32'h101,       32'h900, 32'hA00, 32'h101,       32'hA00, 32'h900}, // R5
    '{3'd3, 8'd5, 32'h100,       32'hA00, 32'hB00, 32'h101,       32'hA00, 32'h900}, // R5
    '{3'd3, 8'd5, 32'h8000_0000, 32'hA00, 32'hB00, 32'h8000_0101, 32'hA00, 32'h900}, // R5
    '{3'd1, 8'd2, 32'h0,         32'hA00, 32'hB00, 32'h8004_0400, 32'hA00, 32'h900}, // R2
    '{3'd1, 8'd2, 32'h0,         32'hA00, 32'hB00, 32'h9010_0000, 32'hA00, 32'h900}, // R2
    '{3'd1, 8'd2, 32'h0,         32'hA00, 32'hB00, 32'h8000_0000, 32'hA00, 32'h900}, // R2
    '{3'd5, 8'd7, 32'h3FFF_FFFF, 32'hA00, 32'hC00, 32'h3FFF_FFFF, 32'hA00, 32'h900}, // R7
    '{3'd2, 8'd3, 32'h0,         32'hA00, 32'hC00, 32'h0003_FFFF, 32'hC00, 32'hA00}, // R3 R4
    '{3'd4, 8'd6, 32'hFFFF_FFFF, 32'hC00, 32'hD00, 32'h0,         32'hC00, 32'hA00}  // R6
  };

  task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply_op(input logic v, input logic [2:0] c, input logic [31:0] d,
                          input logic [31:0] s, input logic [31:0] u);
    @(negedge clk);
    op_valid = v; op_code = c; op_data = d; sp_in = s; usp_in = u;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] s0, p0, k0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("reset stat", 1, stat_q, 32'h0);
    check("reset sp", 1, sp_out, 32'h0);
    check("reset ksp", 1, ksp_q, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply_op(1'b1, VECS[i].op, VECS[i].data, VECS[i].sp, VECS[i].usp);
      check($sformatf("vec %0d stat", i), int'(VECS[i].req), stat_q, VECS[i].xs);
      check($sformatf("vec %0d sp", i), int'(VECS[i].req), sp_out, VECS[i].xsp);
      check($sformatf("vec %0d ksp", i), int'(VECS[i].req), ksp_q, VECS[i].xk);
    end

    // R9: strobe low with a set-flags request, then reserved codes and code 0
    s0 = stat_q; p0 = sp_out; k0 = ksp_q;
    apply_op(1'b0, 3'd3, 32'hFFFF_FFFF, 32'h1234, 32'h5678);
    check("strobe low stat", 9, stat_q, s0);
    check("strobe low sp", 9, sp_out, p0);
    for (int c = 6; c < 9; c++) begin
      apply_op(1'b1, 3'(c % 8), 32'hFFFF_FFFF, 32'h1234, 32'h5678);
      check($sformatf("code %0d stat", c % 8), 9, stat_q, s0);
      check($sformatf("code %0d sp", c % 8), 9, sp_out, p0);
      check($sformatf("code %0d ksp", c % 8), 9, ksp_q, k0);
    end

    // R1: reset again after activity
    apply_op(1'b1, 3'd5, 32'hDEAD_BEEF, 32'h44, 32'h55);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("re-reset stat", 1, stat_q, 32'h0);
    check("re-reset sp", 1, sp_out, 32'h0);
    check("re-reset ksp", 1, ksp_q, 32'h0);
    finish_run();
  end
endmodule